// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block supervises firmware by counting ticks of a slow internal clock, each tick arriving as a one-cycle enable on the system clock. Firmware proves it is alive by writing one particular key byte to the clear port before the count runs out. If the count reaches its terminal value first, the block emits a one-cycle reset request for the chip's reset sequencer. It also sets a sticky flag, so that software can later tell that the restart came from the watchdog.

The terminal count is the product of two divider stages: a prescaler of `PRE_DIV` ticks and a postscaler of `POST_DIV` prescaler wraps. The defaults of 512 and 16 give 8192 slow-clock periods, about half a second at 16 kHz. A configuration enable decides whether the watchdog runs at all, and a sleep indication freezes the count while the slow clock is meant to be stopped. After firing, the counter restarts from zero on its own. If firmware is stuck, for example during a supply dead band, the watchdog keeps firing every timeout period without needing software.

Control is a three-state machine. `WD_OFF` holds the count at zero. `WD_RUN` counts qualifying ticks. `WD_BITE` lasts exactly one cycle and drives the reset request. The transitions are:
- arm: `WD_OFF` to `WD_RUN` when enabled.
- disarm: `WD_RUN` or `WD_BITE` to `WD_OFF` when the enable is low.
- expire: `WD_RUN` to `WD_BITE` on terminal count without a key write in the same cycle.
- rearm: `WD_BITE` to `WD_RUN` when still enabled.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdt_rst` and `wdt_flag` are 0 and the tick count is zero.
- R2: A cycle with `kick_we`=1 and `kick_data`=0x5A restarts the tick count at zero. The restart wins over a terminal tick in the same cycle, so no reset request follows that cycle.
- R3: A write of any byte other than 0x5A has no effect on the count.
- R4: While enabled and awake, the reset request follows exactly `PRE_DIV*POST_DIV` ticks (default 8192) after the last restart.
- R5: `wdt_rst` is high for exactly one clock cycle: the cycle right after the clock edge that samples the terminal tick.
- R6: `wdt_flag` goes to 1 in the same cycle as `wdt_rst`. It stays 1 until a cycle with `flag_clr`=1. When a set and a clear coincide, the set wins.
- R7: While `enable`=0 the count is held at zero and no reset request is made. After re-enabling, counting starts from zero.
- R8: Ticks that arrive while `sleep`=1 are not counted, and the count already reached is kept.
- R9: After firing, the count restarts at zero without any write. A further `PRE_DIV*POST_DIV` ticks cause another reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per slow-clock period |
| enable | input | 1 | Configuration enable for the watchdog |
| sleep | input | 1 | Power-down indication; freezes counting |
| kick_we | input | 1 | Write strobe for the clear port |
| kick_data | input | 8 | Byte written to the clear port |
| flag_clr | input | 1 | Clears the sticky watchdog flag |
| wdt_rst | output | 1 | One-cycle system reset request |
| wdt_flag | output | 1 | Sticky record of a watchdog-caused reset |

## Verification
The bench builds the block with `PRE_DIV`=4 and `POST_DIV`=4, so a timeout takes 16 ticks instead of 8192. This makes it practical to count ticks to the exact terminal value, both one short and on the mark. It also brings the prescaler-to-postscaler carry into every scenario. With the timeout this short, the bench can cover a key write landing on the terminal tick, repeated firing with no clears, and the resumption of counting after disable and sleep, all within a few hundred cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;

    localparam logic [7:0] WD_DEFAULT_KEY = 8'h5A;
endpackage

// File: rtl/wdt_key_match.sv
module wdt_key_match #(
    parameter logic [7:0] KEY = 8'h5A
) (
    input  logic       we,
    input  logic [7:0] data,
    output logic       hit
);
    always_comb begin
        hit = we && (data == KEY);
    end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic carry
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_comb begin
        carry = inc && (cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || carry) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      bite_req,
    input  logic      flag_clr,
    output wd_state_e state,
    output logic      rst_pulse,
    output logic      flag
);
    wd_state_e next;

    always_comb begin
        next = state;
        unique case (state)
            WD_OFF:  next = enable ? WD_RUN : WD_OFF;
            WD_RUN:  begin
                if (!enable)       next = WD_OFF;
                else if (bite_req) next = WD_BITE;
                else               next = WD_RUN;
            end
            WD_BITE: next = enable ? WD_RUN : WD_OFF;
            default: next = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= next;
    end

    always_comb begin
        rst_pulse = (state == WD_BITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (state == WD_RUN && enable && bite_req) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int         PRE_DIV  = 512,
    parameter int         POST_DIV = 16,
    parameter logic [7:0] KEY      = WD_DEFAULT_KEY
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic       sleep,
    input  logic       kick_we,
    input  logic [7:0] kick_data,
    input  logic       flag_clr,
    output logic       wdt_rst,
    output logic       wdt_flag
);
    localparam int NSTAGE = 2;

    wd_state_e          state;
    logic               key_hit;
    logic               count_clr;
    logic               count_inc;
    logic [NSTAGE:0]    chain;
    logic               bite_req;

    wdt_key_match #(.KEY(KEY)) u_key (
        .we   (kick_we),
        .data (kick_data),
        .hit  (key_hit)
    );

    always_comb begin
        count_inc = tick && !sleep && (state == WD_RUN) && enable;
        count_clr = (state != WD_RUN) || !enable || key_hit;
        chain[0]  = count_inc;
        bite_req  = chain[NSTAGE] && !key_hit;
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        localparam int DIV = (g == 0) ? PRE_DIV : POST_DIV;
        wdt_stage #(.DIV(DIV)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (count_clr),
            .inc   (chain[g]),
            .carry (chain[g+1])
        );
    end

    wdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bite_req  (bite_req),
        .flag_clr  (flag_clr),
        .state     (state),
        .rst_pulse (wdt_rst),
        .flag      (wdt_flag)
    );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
    parameter logic [7:0] KEY = 8'h5A
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       kick_we,
    input logic [7:0] kick_data,
    input logic       flag_clr,
    input logic       wdt_rst,
    input logic       wdt_flag
);
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> wdt_flag);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_flag && !flag_clr) |=> wdt_flag);

    a_r2_key_blocks_bite: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_we && kick_data == KEY) |=> !wdt_rst);

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> !wdt_rst);
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.KEY(KEY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .kick_we   (kick_we),
    .kick_data (kick_data),
    .flag_clr  (flag_clr),
    .wdt_rst   (wdt_rst),
    .wdt_flag  (wdt_flag)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
    localparam int PRE  = 4;
    localparam int POST = 4;
    localparam int TERM = PRE * POST;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       enable = 1'b0;
    logic       sleep = 1'b0;
    logic       kick_we = 1'b0;
    logic [7:0] kick_data = 8'h00;
    logic       flag_clr = 1'b0;
    logic       wdt_rst;
    logic       wdt_flag;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int wide = 0;
    logic prev_rst = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog #(.PRE_DIV(PRE), .POST_DIV(POST)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .sleep(sleep),
        .kick_we(kick_we), .kick_data(kick_data), .flag_clr(flag_clr),
        .wdt_rst(wdt_rst), .wdt_flag(wdt_flag)
    );

    always @(negedge clk) begin
        if (wdt_rst) pulses++;
        if (wdt_rst && prev_rst) wide++;
        prev_rst = wdt_rst;
    end

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic kick(input logic [7:0] v);
        kick_we = 1'b1;
        kick_data = v;
        @(negedge clk);
        kick_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check(wdt_rst, 0, "R1 rst low");
        check(wdt_flag, 0, "R1 flag low");
        enable = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_timeout();
        int p0 = pulses;
        ticks(TERM - 1);
        check(pulses - p0, 0, "R4 none before terminal");
        check(wdt_flag, 0, "R6 flag before terminal");
        ticks(1);
        check(pulses - p0, 1, "R4 pulse at terminal");
        check(wide, 0, "R5 single cycle");
        check(wdt_flag, 1, "R6 flag set");
    endtask

    task automatic t_flag_sticky();
        for (int i = 0; i < 10; i++) @(negedge clk);
        check(wdt_flag, 1, "R6 flag sticky");
        clear_flag();
        check(wdt_flag, 0, "R6 flag cleared");
    endtask

    task automatic t_key_clear();
        int p0 = pulses;
        ticks(10);
        kick(8'h5A);
        ticks(TERM - 1);
        check(pulses - p0, 0, "R2 restart after key");
        ticks(1);
        check(pulses - p0, 1, "R2 full period after key");
    endtask

    task automatic t_wrong_key();
        int p0 = pulses;
        ticks(10);
        kick(8'hA5);
        kick(8'h5B);
        kick(8'h00);
        ticks(TERM - 11);
        check(pulses - p0, 0, "R3 one short");
        ticks(1);
        check(pulses - p0, 1, "R3 wrong key ignored");
    endtask

    task automatic t_key_on_terminal();
        int p0 = pulses;
        ticks(TERM - 1);
        tick = 1'b1; kick_we = 1'b1; kick_data = 8'h5A;
        @(negedge clk);
        tick = 1'b0; kick_we = 1'b0;
        @(negedge clk); @(negedge clk);
        check(pulses - p0, 0, "R2 key wins over terminal");
        ticks(TERM - 1);
        check(pulses - p0, 0, "R2 restarted at zero");
        ticks(1);
        check(pulses - p0, 1, "R2 pulse after restart");
    endtask

    task automatic t_disable();
        int p0 = pulses;
        ticks(10);
        enable = 1'b0;
        @(negedge clk); @(negedge clk);
        ticks(3 * TERM);
        check(pulses - p0, 0, "R7 no pulse when off");
        enable = 1'b1;
        @(negedge clk); @(negedge clk);
        ticks(TERM - 1);
        check(pulses - p0, 0, "R7 count from zero");
        ticks(1);
        check(pulses - p0, 1, "R7 pulse after re-enable");
    endtask

    task automatic t_sleep();
        int p0 = pulses;
        ticks(10);
        sleep = 1'b1;
        ticks(3 * TERM);
        check(pulses - p0, 0, "R8 frozen in sleep");
        sleep = 1'b0;
        ticks(TERM - 11);
        check(pulses - p0, 0, "R8 kept count minus one");
        ticks(1);
        check(pulses - p0, 1, "R8 kept count");
    endtask

    task automatic t_repeat();
        int p0 = pulses;
        ticks(TERM);
        check(pulses - p0, 1, "R9 first fire");
        ticks(TERM - 1);
        check(pulses - p0, 1, "R9 restart at zero");
        ticks(1);
        check(pulses - p0, 2, "R9 second fire");
        check(wide, 0, "R5 no wide pulse");
    endtask

    initial begin
        #5_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_timeout();
        t_flag_sticky();
        t_key_clear();
        clear_flag();
        t_wrong_key();
        t_key_on_terminal();
        t_disable();
        t_sleep();
        t_repeat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule